// File: doc/BRIEF.md
# DMA Cache Coherence Sequencer

This block carries out single-block DMA reads and writes against main memory while keeping a write-back, direct-mapped external cache coherent with them. The design assumes one processor, so it has no shared-line state and answers no snoops from other masters. Before it touches the cache, the sequencer takes the cache away from the CPU. It raises a hold request and waits for the CPU to grant it with a hold acknowledge.

A DMA write probes the cache tag at the block's index. On a hit, the sequencer writes the cache line and main memory in the same cycle. It also pulses an invalidate, carrying the block address, toward the CPU's primary data cache. On a miss, only memory is written. The cache is never invalidated by a DMA write; it is either updated or left alone.

A DMA read starts the memory read in the same cycle as the cache probe. Once both have finished, the sequencer returns the cache data if the probe hit and the memory data if it missed. Each transfer ends with a one-cycle completion pulse to the arbiter. Hold request drops in that same cycle, which is one cycle after the memory transfer finishes.

Top module: `dma_coh_seq`

## Requirements
- R1: Hold request rises in the cycle after a DMA request is accepted while idle. The cache enable is never asserted unless both hold request and hold acknowledge are high.
- R2: On a DMA write whose probe hits, the cache write (cache_en and cache_we, with the index, which is the low IDX_W address bits, and the write data) happens in a cycle where memory is also requested with mem_we high.
- R3: A DMA write hit raises inval_valid for exactly one cycle, with inval_addr equal to the full block address, together with the cache write.
- R4: A DMA write miss writes memory only: no cache write and no invalidate, so the cache line at that index keeps its old contents.
- R5: A DMA read raises its memory request in the same cycle as the cache probe (cache_en high, cache_we low).
- R6: A DMA read whose probe hits returns the cache data on dma_rdata during the dma_done cycle, even when memory holds different data.
- R7: A DMA read whose probe misses returns the memory data on dma_rdata during the dma_done cycle.
- R8: dma_done is a one-cycle pulse. Hold request is low during it, and it comes one cycle after the memory acknowledge that completes the transfer.
- R9: A probe hits only when the returned tag equals the address bits above the index (the upper ADDR_W-IDX_W bits). A read never writes the cache.
- R10: The memory request stays high until memory acknowledges it. This holds for any memory latency, including an acknowledge that arrives before the probe result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req | input | 1 | DMA transfer request, held until dma_done |
| dma_we | input | 1 | 1 = DMA write, 0 = DMA read |
| dma_addr | input | ADDR_W | Block address |
| dma_wdata | input | DATA_W | DMA write data |
| dma_done | output | 1 | One-cycle completion pulse to the arbiter |
| dma_rdata | output | DATA_W | DMA read result, valid with dma_done |
| hold_req | output | 1 | Request to the CPU to release the cache |
| hold_ack | input | 1 | CPU has released the cache |
| cache_en | output | 1 | Cache access enable (probe or write) |
| cache_we | output | 1 | Cache data write |
| cache_idx | output | IDX_W | Cache line index |
| cache_wdata | output | DATA_W | Cache write data |
| cache_rtag | input | ADDR_W-IDX_W | Tag read, one cycle after a probe |
| cache_rdata | input | DATA_W | Data read, one cycle after a probe |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write when mem_req is high |
| mem_addr | output | ADDR_W | Memory block address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| inval_valid | output | 1 | Primary data cache invalidate pulse |
| inval_addr | output | ADDR_W | Block address to invalidate |

## Verification
The assertions assume the following about the environment:
- The CPU raises hold acknowledge only while hold request is high, and drops it after hold request falls.
- Memory acknowledges only while mem_req is high, for a single cycle.
- The cache returns its tag and data one cycle after an enabled probe.
- The DMA requester holds its command stable until dma_done.

The bench's CPU, memory and cache models are built to these rules. Hold and memory latencies are set per scenario, from zero cycles upward, so that memory can complete either before or after the tag check.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_PROBE = 3'd2,
    ST_CHECK = 3'd3,
    ST_MEMWT = 3'd4,
    ST_DONE  = 3'd5
  } dcs_state_e;
endpackage

// File: rtl/dcs_rst_sync.sv
module dcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/dcs_cmd_reg.sv
module dcs_cmd_reg #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              in_we,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              cmd_we,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_we    <= 1'b0;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
    end else if (load) begin
      cmd_we    <= in_we;
      cmd_addr  <= in_addr;
      cmd_wdata <= in_wdata;
    end
  end
endmodule

// File: rtl/dcs_ctrl.sv
module dcs_ctrl
  import dcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dma_req,
  input  logic cmd_we,
  input  logic hold_ack,
  input  logic tag_hit,
  input  logic mem_ack,
  output logic load,
  output logic hold_req,
  output logic cache_en,
  output logic cache_we,
  output logic inval_valid,
  output logic mem_req,
  output logic chk_cap,
  output logic mem_cap,
  output logic dma_done
);
  dcs_state_e st_q, st_d;
  logic       mdone_q, mdone_d;
  logic       ack_now;

  assign ack_now = mem_req & mem_ack;

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (dma_req)  st_d = ST_HOLD;
      ST_HOLD:  if (hold_ack) st_d = ST_PROBE;
      ST_PROBE: st_d = ST_CHECK;
      ST_CHECK: begin
        if (cmd_we) st_d = ack_now ? ST_DONE : ST_MEMWT;
        else        st_d = (mdone_q | ack_now) ? ST_DONE : ST_MEMWT;
      end
      ST_MEMWT: if (ack_now)  st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    mdone_d = mdone_q;
    if (load)         mdone_d = 1'b0;
    else if (ack_now) mdone_d = 1'b1;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      mdone_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      mdone_q <= mdone_d;
    end
  end

  // outputs decoded from state
  always_comb begin
    load        = (st_q == ST_IDLE) & dma_req;
    hold_req    = (st_q == ST_HOLD) | (st_q == ST_PROBE) |
                  (st_q == ST_CHECK) | (st_q == ST_MEMWT);
    cache_we    = (st_q == ST_CHECK) & cmd_we & tag_hit;
    cache_en    = (st_q == ST_PROBE) | cache_we;
    inval_valid = cache_we;
    mem_req     = ((st_q == ST_PROBE) & ~cmd_we) |
                  ((st_q == ST_CHECK) & (cmd_we | ~mdone_q)) |
                  (st_q == ST_MEMWT);
    chk_cap     = (st_q == ST_CHECK) & ~cmd_we;
    mem_cap     = ack_now & ~cmd_we;
    dma_done    = (st_q == ST_DONE);
  end
endmodule

// File: rtl/dcs_rd_buf.sv
module dcs_rd_buf #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_cap,
  input  logic              tag_hit,
  input  logic [DATA_W-1:0] cache_rdata,
  input  logic              mem_cap,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cbuf_q, mbuf_q;
  logic              hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cbuf_q <= '0;
      hit_q  <= 1'b0;
    end else if (chk_cap) begin
      cbuf_q <= cache_rdata;
      hit_q  <= tag_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mbuf_q <= '0;
    else if (mem_cap) mbuf_q <= mem_rdata;
  end

  assign rdata = hit_q ? cbuf_q : mbuf_q;
endmodule

// File: rtl/dma_coh_seq.sv
module dma_coh_seq #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_req,
  input  logic              dma_we,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              dma_done,
  output logic [DATA_W-1:0] dma_rdata,
  output logic              hold_req,
  input  logic              hold_ack,
  output logic              cache_en,
  output logic              cache_we,
  output logic [IDX_W-1:0]  cache_idx,
  output logic [DATA_W-1:0] cache_wdata,
  input  logic [TAG_W-1:0]  cache_rtag,
  input  logic [DATA_W-1:0] cache_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              inval_valid,
  output logic [ADDR_W-1:0] inval_addr
);
  logic              srst_n;
  logic              load, cmd_we, tag_hit, chk_cap, mem_cap;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_wdata;

  dcs_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(srst_n)
  );

  dcs_cmd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cmd_i (
    .clk(clk), .rst_n(srst_n), .load(load),
    .in_we(dma_we), .in_addr(dma_addr), .in_wdata(dma_wdata),
    .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata)
  );

  // tag compare on the address bits above the index
  assign tag_hit = (cache_rtag == cmd_addr[ADDR_W-1:IDX_W]);

  dcs_ctrl ctrl_i (
    .clk(clk), .rst_n(srst_n), .dma_req(dma_req), .cmd_we(cmd_we),
    .hold_ack(hold_ack), .tag_hit(tag_hit), .mem_ack(mem_ack),
    .load(load), .hold_req(hold_req), .cache_en(cache_en),
    .cache_we(cache_we), .inval_valid(inval_valid), .mem_req(mem_req),
    .chk_cap(chk_cap), .mem_cap(mem_cap), .dma_done(dma_done)
  );

  dcs_rd_buf #(.DATA_W(DATA_W)) rbuf_i (
    .clk(clk), .rst_n(srst_n), .chk_cap(chk_cap), .tag_hit(tag_hit),
    .cache_rdata(cache_rdata), .mem_cap(mem_cap), .mem_rdata(mem_rdata),
    .rdata(dma_rdata)
  );

  assign cache_idx   = cmd_addr[IDX_W-1:0];
  assign cache_wdata = cmd_wdata;
  assign mem_we      = cmd_we;
  assign mem_addr    = cmd_addr;
  assign mem_wdata   = cmd_wdata;
  assign inval_addr  = cmd_addr;
endmodule

// File: rtl/dcs_chk.sv
module dcs_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold_req,
  input logic              hold_ack,
  input logic              cache_en,
  input logic              cache_we,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic              inval_valid,
  input logic [ADDR_W-1:0] inval_addr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              dma_done
);
  AST_CACHE_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cache_en |-> (hold_req && hold_ack)); // R1
  AST_WR_HIT_PARALLEL: assert property (@(posedge clk) disable iff (!rst_n)
    cache_we |-> (cache_en && mem_req && mem_we)); // R2
  AST_INVAL_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    inval_valid |-> (cache_we && inval_addr == mem_addr)); // R3
  AST_INVAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    inval_valid |=> !inval_valid); // R3
  AST_RD_START_WITH_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req) && !mem_we) |-> (cache_en && !cache_we)); // R5
  AST_DONE_DROPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |-> !hold_req); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> !dma_done); // R8
  AST_ACK_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !cache_en) |=> dma_done); // R8
  AST_NO_CACHE_WR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cache_we |-> mem_we); // R9
  AST_MEMREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req); // R10
endmodule

bind dma_coh_seq dcs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_ack(hold_ack),
  .cache_en(cache_en), .cache_we(cache_we), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .inval_valid(inval_valid),
  .inval_addr(inval_addr), .mem_addr(mem_addr), .dma_done(dma_done)
);

// File: tb/dma_coh_seq_tb_top.sv
module dma_coh_seq_tb_top;
  localparam int AW = 10, IW = 4, DW = 32, TW = AW - IW;

  logic clk, rst_n;
  logic dma_req, dma_we, dma_done;
  logic [AW-1:0] dma_addr;
  logic [DW-1:0] dma_wdata, dma_rdata;
  logic hold_req, hold_ack;
  logic cache_en, cache_we;
  logic [IW-1:0] cache_idx;
  logic [DW-1:0] cache_wdata, cache_rdata;
  logic [TW-1:0] cache_rtag;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr, inval_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic inval_valid;

  dma_coh_seq #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) dut_i (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  // environment models
  logic [TW-1:0] ctag [16];
  logic [DW-1:0] cdat [16];
  logic [DW-1:0] mem  [1024];
  int hold_dly = 0, mem_lat = 0, hcnt = 0, mcnt = 0;
  int no_hold_acc = 0, cw_cnt = 0, cw_nopar = 0, inv_cnt = 0;
  int rd_start = 0, rd_nopar = 0;
  logic [AW-1:0] inv_a;
  logic mreq_d;

  always @(posedge clk) begin
    if (!hold_req) begin hold_ack <= 1'b0; hcnt <= 0; end
    else if (hcnt >= hold_dly) hold_ack <= 1'b1;
    else hcnt <= hcnt + 1;
  end

  always @(posedge clk) begin
    if (cache_en) begin
      cache_rtag  <= ctag[cache_idx];
      cache_rdata <= cdat[cache_idx];
      if (cache_we) cdat[cache_idx] <= cache_wdata;
    end
  end

  always @(posedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (mcnt >= mem_lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mcnt <= 0;
      end else mcnt <= mcnt + 1;
    end
  end

  always @(posedge clk) begin
    mreq_d <= mem_req;
    if (cache_en && !(hold_req && hold_ack)) no_hold_acc <= no_hold_acc + 1;
    if (cache_we) begin
      cw_cnt <= cw_cnt + 1;
      if (!(mem_req && mem_we)) cw_nopar <= cw_nopar + 1;
    end
    if (inval_valid) begin inv_cnt <= inv_cnt + 1; inv_a <= inval_addr; end
    if (mem_req && !mreq_d && !mem_we) begin
      rd_start <= rd_start + 1;
      if (!(cache_en && !cache_we)) rd_nopar <= rd_nopar + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    cw_cnt = 0; cw_nopar = 0; inv_cnt = 0; rd_start = 0; rd_nopar = 0; no_hold_acc = 0;
  endtask

  task automatic run_dma(input logic we, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, output logic [DW-1:0] rd);
    int cyc = 0;
    @(negedge clk);
    dma_req = 1'b1; dma_we = we; dma_addr = a; dma_wdata = wd;
    @(negedge clk);
    check(hold_req == 1'b1, "R1 hold_req after request", 32'(hold_req), 1);
    while (!dma_done && cyc < 200) begin @(negedge clk); cyc++; end
    check(dma_done && !hold_req, "R8 hold low at done", 32'(hold_req), 0);
    rd = dma_rdata;
    dma_req = 1'b0;
    @(negedge clk);
    check(!dma_done, "R8 done single pulse", 32'(dma_done), 0);
  endtask

  task automatic t_write_hit(input int lat);
    logic [DW-1:0] rd;
    logic [AW-1:0] a = {6'h15, 4'h3};
    mem_lat = lat; clear_mon();
    ctag[3] = 6'h15; cdat[3] = 32'h1111_0000; mem[a] = 32'h2222_0000;
    run_dma(1'b1, a, 32'hCAFE_0001 + lat, rd);
    check(cdat[3] == 32'hCAFE_0001 + lat, "R2 cache line updated", cdat[3], 32'hCAFE_0001 + lat);
    check(mem[a] == 32'hCAFE_0001 + lat, "R2 memory updated", mem[a], 32'hCAFE_0001 + lat);
    check(cw_cnt == 1 && cw_nopar == 0, "R2 cache write parallel to memory", cw_nopar, 0);
    check(inv_cnt == 1, "R3 one invalidate", inv_cnt, 1);
    check(inv_a == a, "R3 invalidate address", 32'(inv_a), 32'(a));
    check(mcnt == 0 && !mem_req, "R10 memory request released", 32'(mem_req), 0);
  endtask

  task automatic t_write_miss();
    logic [DW-1:0] rd;
    logic [AW-1:0] a = {6'h02, 4'h5};
    mem_lat = 1; clear_mon();
    ctag[5] = 6'h30; cdat[5] = 32'h5555_AAAA; mem[a] = 32'h0;
    run_dma(1'b1, a, 32'hBEEF_0005, rd);
    check(cdat[5] == 32'h5555_AAAA, "R4 cache unchanged on miss", cdat[5], 32'h5555_AAAA);
    check(mem[a] == 32'hBEEF_0005, "R4 memory written on miss", mem[a], 32'hBEEF_0005);
    check(cw_cnt == 0 && inv_cnt == 0, "R4 no cache write or invalidate", cw_cnt + inv_cnt, 0);
  endtask

  task automatic t_read(input bit hit, input int lat, input int hd);
    logic [DW-1:0] rd;
    logic [AW-1:0] a = {6'h0A, 4'h9};
    mem_lat = lat; hold_dly = hd; clear_mon();
    ctag[9] = hit ? 6'h0A : 6'h0B;   // R9: same index, other tag is a miss
    cdat[9] = 32'hC0C0_0000 + lat; mem[a] = 32'hD0D0_0000 + lat;
    run_dma(1'b0, a, 32'h0, rd);
    if (hit) check(rd == 32'hC0C0_0000 + lat, "R6 read hit returns cache data", rd, 32'hC0C0_0000 + lat);
    else     check(rd == 32'hD0D0_0000 + lat, "R7 read miss returns memory data", rd, 32'hD0D0_0000 + lat);
    check(rd_start == 1 && rd_nopar == 0, "R5 memory read starts with probe", rd_nopar, 0);
    check(cw_cnt == 0 && cdat[9] == 32'hC0C0_0000 + lat, "R9 read leaves cache", cdat[9], 32'hC0C0_0000 + lat);
    check(no_hold_acc == 0, "R1 no cache access without hold", no_hold_acc, 0);
    hold_dly = 0;
  endtask

  initial begin
    rst_n = 1'b0; dma_req = 1'b0; dma_we = 1'b0; dma_addr = '0; dma_wdata = '0;
    hold_ack = 1'b0; mem_ack = 1'b0; mem_rdata = '0; cache_rtag = '0; cache_rdata = '0;
    for (int i = 0; i < 16; i++) begin ctag[i] = 6'h3F; cdat[i] = '0; end
    for (int i = 0; i < 1024; i++) mem[i] = 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!hold_req && !dma_done && !cache_en && !mem_req && !inval_valid,
          "R1 reset state idle", {hold_req, dma_done, cache_en, mem_req}, 0);
    t_write_hit(0);
    t_write_hit(4);
    t_write_miss();
    t_read(1'b1, 0, 0);
    t_read(1'b0, 0, 0);
    t_read(1'b1, 5, 3);   // R10 slow memory, R1 slow hold acknowledge
    t_read(1'b0, 3, 6);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule